// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block evaluates a set of small combinational functions whose shape is loaded at run time. It has a vector of logic inputs, a bank of product terms, and a vector of logic outputs. Each product term is the AND of a programmable selection of inputs. Each selected input is used either as it is or inverted. Each output is the OR of any subset of the product terms. One term can feed several outputs at once, so shared logic is built only once.

The configuration is held in one register word per product term. A word has two parts. The low part holds two bits per input and sets the term's AND cells. The high part holds one bit per output and sets the term's OR connections. Words are written one per clock through a word-wide write port, and any word can be read back combinationally. After reset the outputs stay muted. They are released once every term word has been written at least once.

A three-state load sequencer tracks this condition:
- `CFG_EMPTY` moves to `CFG_FILLING` on the first accepted write, or straight to `CFG_READY` if that write completes the set.
- `CFG_FILLING` moves to `CFG_READY` on the write that covers the last unwritten term.
- `CFG_READY` is held until reset.

Top module: `pla_core`

## Requirements
- R1: After reset, `pla_out` is 0 and `cfg_ready` is 0. Both stay so until every term index 0..N_TERM-1 has been written at least once, even if only some terms have been loaded.
- R2: The AND cell for input i of a term sits at word bits [2i+1:2i]. Code 2'b01 uses the input as it is, 2'b10 uses its complement, and 2'b00 leaves the input out of the term.
- R3: AND cell code 2'b11 forces its product term to 0 for every input value.
- R4: A product term whose AND cells are all 2'b00 evaluates to 1.
- R5: Word bit 2*N_IN+j connects the term to output j. Output j is the OR of its connected terms, and an output with no connected term is 0.
- R6: One term connected to several outputs drives all of them at once.
- R7: A write accepted at a rising edge changes the evaluated function and the readback from that edge on. Before the edge, the old function still holds. `pla_out` follows `pla_in` in the same cycle.
- R8: `cfg_rdata` shows the stored word of term `cfg_raddr` in the same cycle, with no clock edge needed.
- R9: Once `cfg_ready` is 1, it stays 1. Rewriting a term then changes the function immediately, without muting the outputs.
- R10: While `cfg_we` is 0, the stored configuration does not change, whatever `cfg_waddr` and `cfg_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for one term word |
| cfg_waddr | input | TERM_AW | Index of the term being written |
| cfg_wdata | input | 2*N_IN+N_OUT | Term word: AND cells low, OR connections high |
| cfg_raddr | input | TERM_AW | Index of the term to read back |
| cfg_rdata | output | 2*N_IN+N_OUT | Stored word of the addressed term |
| cfg_ready | output | 1 | High once every term has been written |
| pla_in | input | N_IN | Logic inputs |
| pla_out | output | N_OUT | Sum-of-products outputs, 0 while not ready |

## Verification
A write presented before a rising edge is due at that edge. The bench drives each write at a falling edge and samples the outputs one time unit after the next rising edge. It also samples once just before that edge, to confirm the old function still holds. Evaluation and readback have no register on the path, so each input pattern or read address is applied and compared within the same cycle, one time unit later. The ready flag is due on the edge of the completing write and is compared at the same post-edge point.

// File: rtl/pla_pkg.sv
package pla_pkg;
    typedef enum logic [1:0] {
        CELL_OFF  = 2'b00,
        CELL_TRUE = 2'b01,
        CELL_INV  = 2'b10,
        CELL_KILL = 2'b11
    } cell_t;

    typedef enum logic [1:0] {
        CFG_EMPTY   = 2'b00,
        CFG_FILLING = 2'b01,
        CFG_READY   = 2'b10
    } cfg_state_t;
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4,
    localparam int WORD_W  = 2 * N_IN + N_OUT,
    localparam int TERM_AW = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [TERM_AW-1:0]           waddr,
    input  logic [WORD_W-1:0]            wdata,
    input  logic [TERM_AW-1:0]           raddr,
    output logic [WORD_W-1:0]            rdata,
    output logic [N_TERM*2*N_IN-1:0]     and_cfg,
    output logic [N_TERM*N_OUT-1:0]      or_cfg,
    output logic                         ready
);
    import pla_pkg::*;

    logic [WORD_W-1:0] rows [N_TERM];
    logic [N_TERM-1:0] seen_q, seen_d;
    cfg_state_t        state_q, state_d;
    logic              wr_ok, rd_ok;

    assign wr_ok = we && ({1'b0, waddr} < (TERM_AW+1)'(N_TERM));
    assign rd_ok = {1'b0, raddr} < (TERM_AW+1)'(N_TERM);

    always_comb begin
        seen_d = seen_q;
        if (wr_ok) seen_d[waddr] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) rows[t] <= '0;
            seen_q <= '0;
        end else if (wr_ok) begin
            rows[waddr] <= wdata;
            seen_q      <= seen_d;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_EMPTY:   if (wr_ok) state_d = (&seen_d) ? CFG_READY : CFG_FILLING;
            CFG_FILLING: if (&seen_d) state_d = CFG_READY;
            CFG_READY:   state_d = CFG_READY;
            default:     state_d = CFG_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        ready = (state_q == CFG_READY);
        rdata = rd_ok ? rows[raddr] : '0;
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_flat
        assign and_cfg[t*2*N_IN +: 2*N_IN] = rows[t][2*N_IN-1:0];
        assign or_cfg[t*N_OUT +: N_OUT]    = rows[t][WORD_W-1:2*N_IN];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> rows[$past(waddr)] == $past(wdata)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(and_cfg) && $stable(or_cfg)); // R10
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R9
    AST_READY_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> &seen_q); // R1
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8
) (
    input  logic [N_IN-1:0]          in_vec,
    input  logic [N_TERM*2*N_IN-1:0] and_cfg,
    output logic [N_TERM-1:0]        term
);
    import pla_pkg::*;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic hit;
        always_comb begin
            hit = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                unique case (cell_t'(and_cfg[(t*N_IN+i)*2 +: 2]))
                    CELL_OFF:  hit = hit;
                    CELL_TRUE: hit = hit & in_vec[i];
                    CELL_INV:  hit = hit & ~in_vec[i];
                    CELL_KILL: hit = 1'b0;
                    default:   hit = 1'b0;
                endcase
            end
        end
        assign term[t] = hit;
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4
) (
    input  logic [N_TERM-1:0]       term,
    input  logic [N_TERM*N_OUT-1:0] or_cfg,
    output logic [N_OUT-1:0]        sum
);
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [N_TERM-1:0] conn;
        for (genvar t = 0; t < N_TERM; t++) begin : g_col
            assign conn[t] = or_cfg[t*N_OUT + j];
        end
        assign sum[j] = |(term & conn);
    end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4,
    localparam int WORD_W  = 2 * N_IN + N_OUT,
    localparam int TERM_AW = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [TERM_AW-1:0] cfg_waddr,
    input  logic [WORD_W-1:0]  cfg_wdata,
    input  logic [TERM_AW-1:0] cfg_raddr,
    output logic [WORD_W-1:0]  cfg_rdata,
    output logic               cfg_ready,
    input  logic [N_IN-1:0]    pla_in,
    output logic [N_OUT-1:0]   pla_out
);
    logic [N_TERM*2*N_IN-1:0] and_cfg;
    logic [N_TERM*N_OUT-1:0]  or_cfg;
    logic [N_TERM-1:0]        term;
    logic [N_OUT-1:0]         sum;

    pla_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr),
        .wdata(cfg_wdata), .raddr(cfg_raddr), .rdata(cfg_rdata),
        .and_cfg(and_cfg), .or_cfg(or_cfg), .ready(cfg_ready)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec(pla_in), .and_cfg(and_cfg), .term(term)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term(term), .or_cfg(or_cfg), .sum(sum)
    );

    assign pla_out = cfg_ready ? sum : '0;

    AST_MUTED_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |-> pla_out == '0); // R1
endmodule

// File: tb/tb_pla_core.sv
module tb_pla_core;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN = 4, N_TERM = 8, N_OUT = 4;
    localparam int W = 2 * N_IN + N_OUT;
    localparam int AW = 3;

    logic clk = 0, rst_n = 0, cfg_we = 0, cfg_ready;
    logic [AW-1:0] cfg_waddr = '0, cfg_raddr = '0;
    logic [W-1:0] cfg_wdata = '0, cfg_rdata;
    logic [N_IN-1:0] pla_in = '0;
    logic [N_OUT-1:0] pla_out;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [W-1:0] model [N_TERM];

    always #(CLK_PERIOD/2) clk = ~clk;

    pla_core #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .cfg_ready(cfg_ready), .pla_in(pla_in), .pla_out(pla_out)
    );

    function automatic logic [N_OUT-1:0] eval_model(logic [N_IN-1:0] v);
        logic [N_OUT-1:0] o = '0;
        for (int t = 0; t < N_TERM; t++) begin
            logic hit = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                case (model[t][2*i +: 2])
                    2'b01: hit = hit & v[i];
                    2'b10: hit = hit & ~v[i];
                    2'b11: hit = 1'b0;
                    default: hit = hit;
                endcase
            end
            for (int j = 0; j < N_OUT; j++)
                if (model[t][2*N_IN+j]) o[j] = o[j] | hit;
        end
        return o;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_term(int idx, logic [W-1:0] word);
        @(negedge clk);
        cfg_we = 1; cfg_waddr = AW'(idx); cfg_wdata = word;
        @(negedge clk);
        cfg_we = 0;
        model[idx] = word;
    endtask

    task automatic sweep(string req, bit ready_exp);
        for (int v = 0; v < (1 << N_IN); v++) begin
            pla_in = N_IN'(v);
            #1;
            check(req, 32'(pla_out), ready_exp ? 32'(eval_model(N_IN'(v))) : 32'd0);
        end
    endtask

    task automatic clear_all();
        for (int t = 0; t < N_TERM; t++) write_term(t, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int t = 0; t < N_TERM; t++) model[t] = '0;
        #(CLK_PERIOD*2 + 2);
        check("R1 reset out", 32'(pla_out), 0);
        check("R1 reset ready", 32'(cfg_ready), 0);
        rst_n = 1;

        // R1: partial load keeps outputs muted; R4 terms with all cells off
        for (int t = 0; t < N_TERM-1; t++) write_term(t, {4'b1111, 8'h00});
        check("R1 partial ready", 32'(cfg_ready), 0);
        sweep("R1 partial out", 0);

        // R7: final write lands exactly at the edge
        @(negedge clk);
        cfg_we = 1; cfg_waddr = AW'(N_TERM-1); cfg_wdata = {4'b0000, 8'h00};
        model[N_TERM-1] = cfg_wdata;
        pla_in = 4'h5;
        #(CLK_PERIOD/2 - 1);
        check("R7 before edge", 32'(cfg_ready), 0);
        @(posedge clk); #1;
        check("R7 ready after edge", 32'(cfg_ready), 1);
        check("R4 R6 empty term drives all", 32'(pla_out), 32'hF);
        @(negedge clk); cfg_we = 0;

        // R10: strobe low, address and data changing
        @(negedge clk);
        cfg_waddr = 3'd0; cfg_wdata = 12'hABC;
        @(negedge clk);
        cfg_raddr = 3'd0; #1;
        check("R10 no write", 32'(cfg_rdata), 32'(model[0]));
        sweep("R10 function kept", 1);

        // R3: kill code on an otherwise all-off term
        clear_all();
        write_term(2, {4'b1111, 8'b00_11_00_00});
        sweep("R3 kill term", 1);
        check("R3 kill out", 32'(pla_out), 0);

        // R2: in0 true, in1 complement, to out0; in3 off
        clear_all();
        write_term(4, {4'b0001, 8'b00_00_10_01});
        sweep("R2 true/complement", 1);
        pla_in = 4'b1101; #1;
        check("R2 in0 & ~in1", 32'(pla_out), 1);
        pla_in = 4'b0011; #1;
        check("R2 in1 high blocks", 32'(pla_out), 0);

        // R5 R6: BCD to Gray, D=in0 C=in1 B=in2 A=in3, Z=out0 .. W=out3
        write_term(0, {4'b1100, 8'b01_00_00_00});
        write_term(1, {4'b0100, 8'b00_01_00_00});
        write_term(2, {4'b0010, 8'b00_01_10_00});
        write_term(3, {4'b0010, 8'b00_10_01_00});
        write_term(4, {4'b0001, 8'b00_00_01_10});
        write_term(5, {4'b0001, 8'b00_00_10_01});
        write_term(6, '0);
        write_term(7, '0);
        for (int v = 0; v < 10; v++) begin
            pla_in = 4'(v); #1;
            check("R5 R6 bcd gray", 32'(pla_out), 32'(v ^ (v >> 1)));
        end

        // R8 R9 random configurations
        for (int k = 0; k < 20; k++) begin
            for (int t = 0; t < N_TERM; t++) write_term(t, W'($urandom));
            check("R9 ready kept", 32'(cfg_ready), 1);
            for (int t = 0; t < N_TERM; t++) begin
                cfg_raddr = AW'(t); #1;
                check("R8 readback", 32'(cfg_rdata), 32'(model[t]));
            end
            sweep("R2 R5 random", 1);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule